// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned integer by another using binary long division. It produces one quotient bit per clock cycle, starting from the most significant bit. A caller presents a dividend and a divisor and raises a start strobe while the block is idle. The block then runs for exactly `WIDTH` iteration cycles. When it finishes, it pulses `done` for one cycle and holds the quotient on the low result port and the remainder on the high result port, the way a multiply/divide unit fills its low and high result registers.

Each iteration shifts the partial remainder left and brings in the next dividend bit. It then makes a trial subtraction of the divisor. The borrow of that subtraction is the comparison: with no borrow the divisor fits, so the quotient bit is 1 and the difference becomes the new remainder. With a borrow, the quotient bit is 0 and the shifted remainder is kept. A step counter sets the length of the run. A zero divisor is not computed. It is flagged on the cycle after start, with the quotient forced to all ones and the remainder equal to the dividend.

Top module: `seq_divider`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `divByZero` are 0 and both result ports are 0.
- R2: A start seen while idle, with a nonzero divisor, raises `busy` on the next cycle. `busy` stays high for exactly `WIDTH` cycles.
- R3: `done` is high for exactly one cycle. For a nonzero divisor, that cycle is the first cycle in which `busy` is low again, which is `WIDTH`+1 cycles after the start edge.
- R4: When `done` is high and `divByZero` is low, `resultLo` equals the integer quotient floor(dividend / divisor) of the operands captured at start.
- R5: When `done` is high and `divByZero` is low, `resultHi` equals dividend mod divisor, which is always below the divisor.
- R6: A start with a zero divisor never raises `busy`. On the next cycle it asserts `done` and `divByZero` together, with `resultLo` all ones and `resultHi` equal to the dividend.
- R7: A start raised while `busy` is ignored. The running operation keeps its operands and its timing, and no new run follows.
- R8: Between completions, `resultLo` and `resultHi` hold their values.
- R9: Synchronous reset during a run returns the block to idle on the next cycle. No `done` follows for the aborted run, and the results read 0.
- R10: `divByZero` is low whenever `done` reports a division with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start strobe, sampled only while idle |
| dividendIn | input | WIDTH | Unsigned dividend, captured with start |
| divisorIn | input | WIDTH | Unsigned divisor, captured with start |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle completion pulse |
| divByZero | output | 1 | High with `done` when the divisor was zero |
| resultLo | output | WIDTH | Quotient, held until the next completion |
| resultHi | output | WIDTH | Remainder, held until the next completion |

## Verification
The hardest situations to reach from the ports are a start that arrives in the middle of a run and a reset that lands partway through a run. Neither shows up when operations are simply issued back to back. The stimulus raises a second start, with different operands, a few cycles into a run. It then checks that the completion still comes at the original cycle and carries the original quotient and remainder. Another run is cut short by a reset two cycles in, and the bench then watches for longer than a full run to confirm that no completion appears. The cycle-accurate model in the bench runs on both scenarios as well as on edge operands: divisor one, divisor above the dividend, a zero dividend, all-ones operands, a zero divisor and a random sweep.

// File: rtl/divider_pkg.sv
package divider_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } divState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;      // capture operands, clear partial remainder
    logic zeroTrap;  // divisor was zero: write forced results
    logic step;      // perform one shift/subtract iteration
    logic finish;    // this step is the last: publish results
  } divStrobes_t;

endpackage

// File: rtl/divider_ctrl.sv
module divider_ctrl
  import divider_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  input  logic        divisorZero,
  output divStrobes_t strobes,
  output logic        busy,
  output logic        done,
  output logic        divByZero
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  divState_t      state;
  logic [CW-1:0]  stepCount;
  logic           accept;

  assign accept = (state == ST_IDLE) && startReq;

  always_comb begin
    strobes          = '0;
    strobes.load     = accept;
    strobes.zeroTrap = accept && divisorZero;
    strobes.step     = (state == ST_RUN);
    strobes.finish   = (state == ST_RUN) && (stepCount == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      stepCount <= '0;
      done      <= 1'b0;
      divByZero <= 1'b0;
    end else begin
      done      <= strobes.finish || strobes.zeroTrap;
      divByZero <= strobes.zeroTrap;
      unique case (state)
        ST_IDLE: begin
          stepCount <= '0;
          if (accept && !divisorZero) state <= ST_RUN;
        end
        ST_RUN: begin
          if (strobes.finish) begin
            state     <= ST_IDLE;
            stepCount <= '0;
          end else begin
            stepCount <= stepCount + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/divider_datapath.sv
module divider_datapath
  import divider_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobes_t      strobes,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic             divisorZero,
  output logic [WIDTH-1:0] resultLo,
  output logic [WIDTH-1:0] resultHi,
  output logic [WIDTH-1:0] opDividend,
  output logic [WIDTH-1:0] opDivisor
);

  logic [WIDTH-1:0] remReg;   // partial remainder
  logic [WIDTH-1:0] quoReg;   // dividend bits shift out, quotient bits shift in
  logic [WIDTH:0]   shifted;
  logic [WIDTH:0]   trial;
  logic             fits;
  logic [WIDTH-1:0] nextRem;
  logic [WIDTH-1:0] nextQuo;

  assign divisorZero = (divisorIn == '0);

  // append the next dividend bit to the remainder
  assign shifted = {remReg, quoReg[WIDTH-1]};
  // trial subtraction doubles as the compare: top bit is the borrow
  assign trial   = shifted - {1'b0, opDivisor};
  assign fits    = !trial[WIDTH];
  assign nextRem = fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
  assign nextQuo = {quoReg[WIDTH-2:0], 1'b0} | {{(WIDTH-1){1'b0}}, fits};

  always_ff @(posedge clk) begin
    if (rst) begin
      remReg     <= '0;
      quoReg     <= '0;
      opDividend <= '0;
      opDivisor  <= '0;
      resultLo   <= '0;
      resultHi   <= '0;
    end else begin
      if (strobes.load) begin
        remReg     <= '0;
        quoReg     <= dividendIn;
        opDividend <= dividendIn;
        opDivisor  <= divisorIn;
      end else if (strobes.step) begin
        remReg <= nextRem;
        quoReg <= nextQuo;
      end
      if (strobes.zeroTrap) begin
        resultLo <= '1;
        resultHi <= dividendIn;
      end else if (strobes.finish) begin
        resultLo <= nextQuo;
        resultHi <= nextRem;
      end
    end
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import divider_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic             busy,
  output logic             done,
  output logic             divByZero,
  output logic [WIDTH-1:0] resultLo,
  output logic [WIDTH-1:0] resultHi
);

  divStrobes_t      strobes;
  logic             divisorZero;
  logic [WIDTH-1:0] opDividend;
  logic [WIDTH-1:0] opDivisor;

  divider_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .startReq    (startReq),
    .divisorZero (divisorZero),
    .strobes     (strobes),
    .busy        (busy),
    .done        (done),
    .divByZero   (divByZero)
  );

  divider_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .dividendIn  (dividendIn),
    .divisorIn   (divisorIn),
    .divisorZero (divisorZero),
    .resultLo    (resultLo),
    .resultHi    (resultHi),
    .opDividend  (opDividend),
    .opDivisor   (opDivisor)
  );

endmodule

// File: rtl/seq_divider_checker.sv
module seq_divider_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             startReq,
  input logic             busy,
  input logic             done,
  input logic             divByZero,
  input logic [WIDTH-1:0] resultLo,
  input logic [WIDTH-1:0] resultHi,
  input logic [WIDTH-1:0] opDividend,
  input logic [WIDTH-1:0] opDivisor
);

  localparam int CW = $clog2(WIDTH + 2);
  localparam int PW = 2 * WIDTH;

  logic [CW-1:0] runLen;
  logic [PW-1:0] recombined;

  always_ff @(posedge clk) begin
    if (rst)       runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  assign recombined = PW'(resultLo) * PW'(opDivisor) + PW'(resultHi);

  // R2: a run lasts exactly WIDTH cycles unless reset cut it
  a_r2_run_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(rst) |-> runLen == CW'(WIDTH));

  // R3: completion is a single-cycle pulse
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: a run that ends normally reports done as busy drops
  a_r3_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(rst) |-> done);

  // R4, R5: quotient and remainder recombine to the dividend
  a_r4_r5_recombine: assert property (@(posedge clk) disable iff (rst)
    done && !divByZero |-> (resultHi < opDivisor) && (recombined == PW'(opDividend)));

  // R6: zero-divisor flag only with done and never during a run
  a_r6_flag_with_done: assert property (@(posedge clk) disable iff (rst)
    divByZero |-> done && !busy);

  // R7: start during a run does not disturb captured operands
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && startReq |=> $stable(opDividend) && $stable(opDivisor));

  // R8: results change only on a completion
  a_r8_results_hold: assert property (@(posedge clk) disable iff (rst)
    !done && !$past(rst) |-> $stable(resultLo) && $stable(resultHi));

  // R2: busy only rises from an accepted start
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(startReq));

endmodule

bind seq_divider seq_divider_checker #(.WIDTH(WIDTH)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .startReq   (startReq),
  .busy       (busy),
  .done       (done),
  .divByZero  (divByZero),
  .resultLo   (resultLo),
  .resultHi   (resultHi),
  .opDividend (opDividend),
  .opDivisor  (opDivisor)
);

// File: tb/seq_divider_bench.sv
`timescale 1ns/1ps
module seq_divider_bench;

  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         startReq = 1'b0;
  logic [W-1:0] dividendIn = '0;
  logic [W-1:0] divisorIn = '0;
  logic         busy, done, divByZero;
  logic [W-1:0] resultLo, resultHi;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  seq_divider #(.WIDTH(W)) u_seq_divider (
    .clk(clk), .rst(rst), .startReq(startReq),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .busy(busy), .done(done), .divByZero(divByZero),
    .resultLo(resultLo), .resultHi(resultHi)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: updated on each rising edge from sampled inputs
  bit mBusy = 0, mDone = 0, mDbz = 0;
  int mLo = 0, mHi = 0, mLeft = 0, mA = 0, mB = 0;

  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mDone = 0; mDbz = 0; mLo = 0; mHi = 0; mLeft = 0;
    end else begin
      mDone = 0; mDbz = 0;
      if (!mBusy && startReq) begin
        if (divisorIn == 0) begin
          mDone = 1; mDbz = 1; mLo = MAXV; mHi = int'(dividendIn);
        end else begin
          mBusy = 1; mLeft = W; mA = int'(dividendIn); mB = int'(divisorIn);
        end
      end else if (mBusy) begin
        mLeft--;
        if (mLeft == 0) begin
          mBusy = 0; mDone = 1; mLo = mA / mB; mHi = mA % mB;
        end
      end
    end
  end

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #3;
    if (!finished) begin
      check(busy == mBusy, "R2", "busy", busy, mBusy);
      check(done == mDone, "R3", "done", done, mDone);
      check(int'(resultLo) == mLo, "R4", "resultLo", resultLo, mLo);
      check(int'(resultHi) == mHi, "R5", "resultHi", resultHi, mHi);
      check(divByZero == mDbz, "R6", "divByZero", divByZero, mDbz);
    end
  end

  task automatic startOp(input int a, input int b);
    @(negedge clk);
    startReq = 1'b1; dividendIn = W'(a); divisorIn = W'(b);
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // returns number of negedges until done seen
  task automatic waitDone(output int n);
    n = 0;
    while (!done && n < 4 * W) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic directedOp(input int a, input int b);
    int n;
    startOp(a, b);
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    waitDone(n);
    check(n == W, "R3", "cycles to done", n, W);
    check(busy == 1'b0, "R3", "busy with done", busy, 0);
    check(int'(resultLo) == a / b, "R4", "quotient", resultLo, a / b);
    check(int'(resultHi) == a % b, "R5", "remainder", resultHi, a % b);
    check(divByZero == 1'b0, "R10", "flag on valid divide", divByZero, 0);
    @(negedge clk);
    check(done == 1'b0, "R3", "done width", done, 0);
    repeat (3) @(negedge clk);
    check(int'(resultLo) == a / b, "R8", "quotient held", resultLo, a / b);
    check(int'(resultHi) == a % b, "R8", "remainder held", resultHi, a % b);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && divByZero == 0, "R1", "status after reset",
          {busy, done, divByZero}, 0);
    check(resultLo == 0 && resultHi == 0, "R1", "results after reset",
          {resultLo, resultHi}, 0);
    rst = 1'b0;

    directedOp(200, 7);
    directedOp(255, 1);
    directedOp(255, 255);
    directedOp(5, 9);
    directedOp(0, 3);
    directedOp(128, 2);
    directedOp(254, 255);

    // R6: zero divisor
    startOp(100, 0);
    check(done == 1 && divByZero == 1, "R6", "flag and done", {done, divByZero}, 3);
    check(busy == 0, "R6", "busy stays low", busy, 0);
    check(int'(resultLo) == MAXV, "R6", "quotient all ones", resultLo, MAXV);
    check(int'(resultHi) == 100, "R6", "remainder is dividend", resultHi, 100);
    @(negedge clk);
    check(done == 0 && divByZero == 0, "R6", "flag pulse width", {done, divByZero}, 0);

    // R7: start while busy ignored
    startOp(171, 13);
    repeat (2) @(negedge clk);
    startReq = 1'b1; dividendIn = 8'd9; divisorIn = 8'd2;
    @(negedge clk);
    startReq = 1'b0;
    waitDone(n);
    check(n == W - 3, "R7", "timing kept", n, W - 3);
    check(int'(resultLo) == 171 / 13, "R7", "quotient of first op", resultLo, 171 / 13);
    check(int'(resultHi) == 171 % 13, "R7", "remainder of first op", resultHi, 171 % 13);
    repeat (W + 2) @(negedge clk);
    check(busy == 0, "R7", "no second run", busy, 0);

    // R9: reset mid-run
    startOp(77, 5);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 0, "R9", "idle after reset", busy, 0);
    n = 0;
    repeat (W + 3) begin
      @(negedge clk);
      if (done) n++;
    end
    check(n == 0, "R9", "no done after abort", n, 0);
    check(resultLo == 0 && resultHi == 0, "R9", "results cleared", {resultLo, resultHi}, 0);

    // random sweep, checked by the per-cycle model
    for (int i = 0; i < 300; i++) begin
      int a, b;
      a = int'($urandom_range(0, MAXV));
      b = (i % 17 == 0) ? 0 : int'($urandom_range(1, MAXV));
      startOp(a, b);
      waitDone(n);
      @(negedge clk);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule